// File: doc/BRIEF.md
# Sorted Memory Trace Consistency Checker

This block watches a stream of word-level memory-trace rows and reports every way in which the stream breaks the consistency rules of a sorted access log. Each row carries an access step, an operation selector, a write selector, a word address, an end-of-address marker and a 256-bit word value split into eight 32-bit limbs. The rows must be ordered by address first and by step second. Within one address, a read must return the word left by the previous row. Every address group must open with a write. Filler rows that follow the real accesses must obey a fixed pattern. The checker does not hold any memory contents. It only compares each row with the row before it.

A producer presents at most one row per clock with `row_valid_i`. There is no ready signal, so the checker never back-pressures. Idle cycles may appear anywhere. `frame_start_i` marks the first row of a frame and is honoured only together with `row_valid_i`. `row_final_i` marks the last row. The checker keeps a copy of the previous row and judges a row one clock after capturing it. Each broken rule sets its own sticky bit in `err_flags_o`, and `err_any_o` is the OR of those bits. The bits are cleared when the first row of the next frame is evaluated. That evaluation also adds any faults of that first row.

Top module: `trace_order_checker`

## Requirements
- R1: A row whose op, wr or last selector holds any value other than 0 or 1 sets flag bit 0.
- R2: A row with op equal to 0 and wr not equal to 0 sets flag bit 1.
- R3: When a row has last equal to 0, the next row of the frame must carry the same address, otherwise flag bit 2 is set.
- R4: Between two consecutive rows of a frame, the address gap (when the earlier last is 1) or the step gap (otherwise) must lie in 1..ROWS as an unsigned modular difference, otherwise flag bit 3 is set. No pair spans two frames.
- R5: A row that is not a write (a write is op equal to 1 and wr equal to 1) and follows a row with last equal to 0 must repeat all eight limbs of that row, otherwise flag bit 4 is set.
- R6: A row that is not a write and follows a row with last equal to 1 must have an all-zero value, otherwise flag bit 5 is set.
- R7: A row with op equal to 1 that opens an address group must be a write, otherwise flag bit 6 is set. A row opens an address group when it is the first row of a frame or follows a row with last equal to 1.
- R8: The row marked final must have last equal to 1, otherwise flag bit 7 is set.
- R9: A filler row (op equal to 0) must have an all-zero value. Its address must be one above that of a preceding real row. After a preceding filler row, it must keep the same address and increase the step by exactly 1. A real row after a filler row is also an error. Any of these faults sets flag bit 8.
- R10: A final row whose position in the frame differs from ROWS sets flag bit 9.
- R11: Flags are zero after reset and stay sticky. A fault in a row captured at clock edge k is visible after edge k+1. The first row of a new frame replaces all flags with that row's own faults. `err_any_o` is 1 exactly when some flag is set.
- R12: A row can be accepted on every clock, and idle cycles between rows neither form pairs nor change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Row on this cycle is the first of a frame |
| row_valid_i | input | 1 | A row is present on this cycle |
| row_final_i | input | 1 | Row on this cycle is the last of the frame |
| step_i | input | 32 | Access step of the row |
| op_i | input | 2 | Operation selector (legal 0 or 1) |
| wr_i | input | 2 | Write selector (legal 0 or 1) |
| addr_i | input | 32 | Word address of the row |
| last_i | input | 2 | End-of-address-group marker (legal 0 or 1) |
| val_i | input | 256 | Word value, limb k at bits 32k+31..32k |
| err_flags_o | output | 10 | Sticky per-rule fault bits, positions as in R1..R10 |
| err_any_o | output | 1 | OR of all fault bits |

## Verification
Four behaviours are checked by assertions on every cycle. Flags never drop between frame starts. A write selector raised without an operation is flagged two edges later. A final row without its end marker is flagged, and so is a frame that opens with a read. The ordering gaps, value carry, zero fill, filler pattern and frame length depend on whole sequences of rows. They are shown only by the bench, which sends one legal frame and then corrupts single fields at chosen rows. The bench also covers idle gaps between rows and the two-edge flag latency.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;
    parameter int unsigned STEP_W = 32;
    parameter int unsigned ADDR_W = 32;
    parameter int unsigned LIMBS  = 8;
    parameter int unsigned LIMB_W = 32;
    parameter int unsigned SEL_W  = 2;
    localparam int unsigned VAL_W = LIMBS * LIMB_W;

    localparam int unsigned ERR_SEL      = 0;
    localparam int unsigned ERR_WRNOP    = 1;
    localparam int unsigned ERR_ADDRHOLD = 2;
    localparam int unsigned ERR_ORDER    = 3;
    localparam int unsigned ERR_CARRY    = 4;
    localparam int unsigned ERR_ZERO     = 5;
    localparam int unsigned ERR_FIRSTWR  = 6;
    localparam int unsigned ERR_FINAL    = 7;
    localparam int unsigned ERR_PAD      = 8;
    localparam int unsigned ERR_LEN      = 9;
    localparam int unsigned NUM_ERR      = 10;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [SEL_W-1:0]  op;
        logic [SEL_W-1:0]  wr;
        logic [SEL_W-1:0]  last;
        logic [ADDR_W-1:0] addr;
        logic              fin;
        logic [VAL_W-1:0]  val;
    } row_t;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [SEL_W-1:0]  op;
        logic [SEL_W-1:0]  last;
        logic [ADDR_W-1:0] addr;
        logic [VAL_W-1:0]  val;
    } prior_t;
endpackage

// File: rtl/trc_capture.sv
`timescale 1ns/1ps
module trc_capture
    import trc_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             valid_i,
    input  row_t             row_i,
    output row_t             cur_o,
    output prior_t           prev_o,
    output logic             cur_v_o,
    output logic             pair_v_o,
    output logic             first_o,
    output logic [CNT_W-1:0] idx_o
);
    typedef struct packed {
        row_t             cur;
        prior_t           prev;
        logic             cur_v;
        logic             pair_v;
        logic             first;
        logic             seen;
        logic [CNT_W-1:0] idx;
    } cap_t;

    cap_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.cur_v = 1'b0;
        if (valid_i) begin
            s_d.prev.step = s_q.cur.step;
            s_d.prev.op   = s_q.cur.op;
            s_d.prev.last = s_q.cur.last;
            s_d.prev.addr = s_q.cur.addr;
            s_d.prev.val  = s_q.cur.val;
            s_d.cur       = row_i;
            s_d.cur_v     = 1'b1;
            s_d.first     = start_i;
            s_d.pair_v    = !start_i && s_q.seen;
            s_d.seen      = 1'b1;
            if (start_i) begin
                s_d.idx = CNT_W'(1);
            end else if (s_q.idx != '1) begin
                s_d.idx = s_q.idx + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_o    = s_q.cur;
    assign prev_o   = s_q.prev;
    assign cur_v_o  = s_q.cur_v;
    assign pair_v_o = s_q.pair_v;
    assign first_o  = s_q.first;
    assign idx_o    = s_q.idx;
endmodule

// File: rtl/trc_row_rules.sv
`timescale 1ns/1ps
module trc_row_rules
    import trc_pkg::*;
#(
    parameter int unsigned ROWS  = 8,
    parameter int unsigned CNT_W = 5
) (
    input  logic               cur_v_i,
    input  logic               first_i,
    input  logic               pair_v_i,
    input  logic [SEL_W-1:0]   op_i,
    input  logic [SEL_W-1:0]   wr_i,
    input  logic [SEL_W-1:0]   last_i,
    input  logic               fin_i,
    input  logic [VAL_W-1:0]   val_i,
    input  logic [SEL_W-1:0]   prior_last_i,
    input  logic [CNT_W-1:0]   idx_i,
    output logic [NUM_ERR-1:0] viol_o
);
    localparam logic [SEL_W-1:0] SEL_ONE  = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_ZERO = '0;

    logic grp_start;

    always_comb begin
        viol_o    = '0;
        grp_start = first_i || !pair_v_i || (prior_last_i == SEL_ONE);
        if (cur_v_i) begin
            viol_o[ERR_SEL]     = (op_i > SEL_ONE) || (wr_i > SEL_ONE) || (last_i > SEL_ONE);
            viol_o[ERR_WRNOP]   = (op_i == SEL_ZERO) && (wr_i != SEL_ZERO);
            viol_o[ERR_FIRSTWR] = grp_start && (op_i == SEL_ONE) && (wr_i != SEL_ONE);
            viol_o[ERR_FINAL]   = fin_i && (last_i != SEL_ONE);
            viol_o[ERR_PAD]     = (op_i == SEL_ZERO) && (val_i != '0);
            viol_o[ERR_LEN]     = fin_i && (idx_i != CNT_W'(ROWS));
        end
    end
endmodule

// File: rtl/trc_pair_rules.sv
`timescale 1ns/1ps
module trc_pair_rules
    import trc_pkg::*;
#(
    parameter int unsigned ROWS = 8
) (
    input  logic               pair_ok_i,
    input  logic [STEP_W-1:0]  cur_step_i,
    input  logic [SEL_W-1:0]   cur_op_i,
    input  logic [SEL_W-1:0]   cur_wr_i,
    input  logic [ADDR_W-1:0]  cur_addr_i,
    input  logic [VAL_W-1:0]   cur_val_i,
    input  logic [STEP_W-1:0]  prv_step_i,
    input  logic [SEL_W-1:0]   prv_op_i,
    input  logic [SEL_W-1:0]   prv_last_i,
    input  logic [ADDR_W-1:0]  prv_addr_i,
    input  logic [VAL_W-1:0]   prv_val_i,
    output logic [NUM_ERR-1:0] viol_o
);
    localparam logic [SEL_W-1:0] SEL_ONE  = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_ZERO = '0;

    logic [LIMBS-1:0] limb_eq;
    logic [LIMBS-1:0] limb_zero;

    for (genvar k = 0; k < LIMBS; k++) begin : g_limb
        assign limb_eq[k]   = cur_val_i[k*LIMB_W +: LIMB_W] == prv_val_i[k*LIMB_W +: LIMB_W];
        assign limb_zero[k] = cur_val_i[k*LIMB_W +: LIMB_W] == '0;
    end

    logic [STEP_W-1:0] step_gap;
    logic [ADDR_W-1:0] addr_gap;
    logic              cur_write, grp_end, grp_hold, step_ok, addr_ok;

    always_comb begin
        viol_o    = '0;
        step_gap  = cur_step_i - prv_step_i;
        addr_gap  = cur_addr_i - prv_addr_i;
        step_ok   = (step_gap != '0) && (step_gap <= STEP_W'(ROWS));
        addr_ok   = (addr_gap != '0) && (addr_gap <= ADDR_W'(ROWS));
        cur_write = (cur_op_i == SEL_ONE) && (cur_wr_i == SEL_ONE);
        grp_end   = prv_last_i == SEL_ONE;
        grp_hold  = prv_last_i == SEL_ZERO;
        if (pair_ok_i) begin
            viol_o[ERR_ADDRHOLD] = grp_hold && (cur_addr_i != prv_addr_i);
            viol_o[ERR_ORDER]    = grp_end ? !addr_ok : !step_ok;
            viol_o[ERR_CARRY]    = !cur_write && grp_hold && !(&limb_eq);
            viol_o[ERR_ZERO]     = !cur_write && grp_end && !(&limb_zero);
            if (cur_op_i == SEL_ZERO) begin
                if (prv_op_i == SEL_ZERO) begin
                    viol_o[ERR_PAD] = (cur_step_i != prv_step_i + STEP_W'(1))
                                   || (cur_addr_i != prv_addr_i);
                end else begin
                    viol_o[ERR_PAD] = cur_addr_i != prv_addr_i + ADDR_W'(1);
                end
            end else begin
                viol_o[ERR_PAD] = prv_op_i == SEL_ZERO;
            end
        end
    end
endmodule

// File: rtl/trc_err_bank.sv
`timescale 1ns/1ps
module trc_err_bank
    import trc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_i,
    input  logic               clr_i,
    input  logic [NUM_ERR-1:0] viol_i,
    output logic [NUM_ERR-1:0] flags_o
);
    logic [NUM_ERR-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (ev_i) flags_d = (clr_i ? '0 : flags_q) | viol_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_i && clr_i) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/trace_order_checker.sv
`timescale 1ns/1ps
module trace_order_checker
    import trc_pkg::*;
#(
    parameter int unsigned ROWS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start_i,
    input  logic               row_valid_i,
    input  logic               row_final_i,
    input  logic [STEP_W-1:0]  step_i,
    input  logic [SEL_W-1:0]   op_i,
    input  logic [SEL_W-1:0]   wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [SEL_W-1:0]   last_i,
    input  logic [VAL_W-1:0]   val_i,
    output logic [NUM_ERR-1:0] err_flags_o,
    output logic               err_any_o
);
    localparam int unsigned CNT_W = $clog2(ROWS) + 2;

    row_t               row_in, cur;
    prior_t             prev;
    logic               cur_v, pair_v, first;
    logic [CNT_W-1:0]   idx;
    logic [NUM_ERR-1:0] row_viol, pair_viol;

    always_comb begin
        row_in.step = step_i;
        row_in.op   = op_i;
        row_in.wr   = wr_i;
        row_in.last = last_i;
        row_in.addr = addr_i;
        row_in.fin  = row_final_i;
        row_in.val  = val_i;
    end

    trc_capture #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .start_i(frame_start_i), .valid_i(row_valid_i),
        .row_i(row_in), .cur_o(cur), .prev_o(prev), .cur_v_o(cur_v),
        .pair_v_o(pair_v), .first_o(first), .idx_o(idx)
    );

    trc_row_rules #(.ROWS(ROWS), .CNT_W(CNT_W)) u_row (
        .cur_v_i(cur_v), .first_i(first), .pair_v_i(pair_v),
        .op_i(cur.op), .wr_i(cur.wr), .last_i(cur.last), .fin_i(cur.fin),
        .val_i(cur.val), .prior_last_i(prev.last), .idx_i(idx), .viol_o(row_viol)
    );

    trc_pair_rules #(.ROWS(ROWS)) u_pair (
        .pair_ok_i(cur_v && pair_v),
        .cur_step_i(cur.step), .cur_op_i(cur.op), .cur_wr_i(cur.wr),
        .cur_addr_i(cur.addr), .cur_val_i(cur.val),
        .prv_step_i(prev.step), .prv_op_i(prev.op), .prv_last_i(prev.last),
        .prv_addr_i(prev.addr), .prv_val_i(prev.val), .viol_o(pair_viol)
    );

    trc_err_bank u_err (
        .clk(clk), .rst_n(rst_n), .ev_i(cur_v), .clr_i(first),
        .viol_i(row_viol | pair_viol), .flags_o(err_flags_o)
    );

    assign err_any_o = |err_flags_o;

    // R2
    wr_without_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid_i && op_i == '0 && wr_i != '0) |=> ##1 err_flags_o[ERR_WRNOP]);

    // R8
    final_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid_i && row_final_i && last_i != SEL_W'(1)) |=> ##1 err_flags_o[ERR_FINAL]);

    // R7
    open_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid_i && frame_start_i && op_i == SEL_W'(1) && wr_i == '0)
        |=> ##1 err_flags_o[ERR_FIRSTWR]);
endmodule

// File: tb/sim_trace_order_checker.sv
`timescale 1ns/1ps
module sim_trace_order_checker;
    import trc_pkg::*;

    typedef struct packed {
        logic [31:0] step;
        logic [1:0]  op;
        logic [1:0]  wr;
        logic [31:0] addr;
        logic [1:0]  last;
        logic [7:0]  seed;
    } rowspec_t;

    typedef struct packed {
        logic [3:0]  len;
        logic [3:0]  row;
        logic [3:0]  kind;
        logic [31:0] value;
        logic [9:0]  exp;
    } case_t;

    // legal eight-row frame: three address groups then two filler rows
    localparam rowspec_t [0:7] BASE = '{
        '{32'd3, 2'd1, 2'd1, 32'd2, 2'd1, 8'h11},
        '{32'd2, 2'd1, 2'd1, 32'd4, 2'd0, 8'h22},
        '{32'd5, 2'd1, 2'd0, 32'd4, 2'd1, 8'h22},
        '{32'd1, 2'd1, 2'd1, 32'd6, 2'd0, 8'h33},
        '{32'd4, 2'd1, 2'd0, 32'd6, 2'd0, 8'h33},
        '{32'd7, 2'd1, 2'd1, 32'd6, 2'd1, 8'h44},
        '{32'd8, 2'd0, 2'd0, 32'd7, 2'd0, 8'h00},
        '{32'd9, 2'd0, 2'd0, 32'd7, 2'd1, 8'h00}
    };

    // kind: 0 none, 1 op, 2 wr, 3 last, 4 step, 5 addr, 6 value seed
    localparam int NCASE = 13;
    localparam case_t [0:NCASE-1] CASES = '{
        '{4'd8, 4'd0, 4'd0, 32'd0,     10'h000},
        '{4'd8, 4'd4, 4'd2, 32'd2,     10'h001},
        '{4'd8, 4'd6, 4'd2, 32'd1,     10'h002},
        '{4'd8, 4'd1, 4'd3, 32'd1,     10'h068},
        '{4'd8, 4'd4, 4'd5, 32'd5,     10'h004},
        '{4'd8, 4'd4, 4'd4, 32'd1,     10'h008},
        '{4'd8, 4'd2, 4'd6, 32'h55,    10'h010},
        '{4'd8, 4'd7, 4'd3, 32'd0,     10'h080},
        '{4'd8, 4'd7, 4'd4, 32'd10,    10'h100},
        '{4'd8, 4'd6, 4'd5, 32'd8,     10'h104},
        '{4'd8, 4'd6, 4'd6, 32'h66,    10'h130},
        '{4'd8, 4'd3, 4'd2, 32'd0,     10'h060},
        '{4'd7, 4'd6, 4'd3, 32'd1,     10'h200}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frame_start_i = 1'b0, row_valid_i = 1'b0, row_final_i = 1'b0;
    logic [STEP_W-1:0]  step_i = '0;
    logic [SEL_W-1:0]   op_i = '0, wr_i = '0, last_i = '0;
    logic [ADDR_W-1:0]  addr_i = '0;
    logic [VAL_W-1:0]   val_i = '0;
    logic [NUM_ERR-1:0] err_flags_o;
    logic               err_any_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trace_order_checker #(.ROWS(8)) u0 (.*);

    function automatic logic [VAL_W-1:0] mk_val(input logic [7:0] seed);
        logic [VAL_W-1:0] v = '0;
        for (int k = 0; k < LIMBS; k++)
            v[k*LIMB_W +: LIMB_W] = (seed == 8'h00) ? '0 : LIMB_W'({seed, seed, seed, 8'(k)});
        return v;
    endfunction

    function automatic string req_of(input int i);
        case (i)
            0: return "R4 clean frame";   1: return "R1";   2: return "R2";
            3: return "R4/R6/R7";         4: return "R3";   5: return "R4";
            6: return "R5";               7: return "R8";   8: return "R9 step";
            9: return "R9 addr";         10: return "R9 value"; 11: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input rowspec_t r, input logic st, input logic fin);
        frame_start_i = st; row_valid_i = 1'b1; row_final_i = fin;
        step_i = r.step; op_i = r.op; wr_i = r.wr; addr_i = r.addr;
        last_i = r.last; val_i = mk_val(r.seed);
        @(negedge clk);
        row_valid_i = 1'b0; frame_start_i = 1'b0; row_final_i = 1'b0;
    endtask

    task automatic send_frame(input case_t c, input int gap);
        for (int r = 0; r < int'(c.len); r++) begin
            rowspec_t s = BASE[r];
            if (r == int'(c.row)) begin
                case (c.kind)
                    4'd1: s.op   = c.value[1:0];
                    4'd2: s.wr   = c.value[1:0];
                    4'd3: s.last = c.value[1:0];
                    4'd4: s.step = c.value;
                    4'd5: s.addr = c.value;
                    4'd6: s.seed = c.value[7:0];
                    default: ;
                endcase
            end
            drive(s, r == 0, r == int'(c.len) - 1);
            repeat (gap) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset flags", 32'(err_flags_o), 32'h0);
        chk("R11 reset any", 32'(err_any_o), 32'h0);

        for (int i = 0; i < NCASE; i++) begin
            send_frame(CASES[i], 0);
            chk(req_of(i), 32'(err_flags_o), 32'(CASES[i].exp));
            chk("R11 any", 32'(err_any_o), 32'(CASES[i].exp != 10'h0));
        end

        // R11 sticky: the R10 fault must survive idle cycles
        repeat (20) @(negedge clk);
        chk("R11 sticky", 32'(err_flags_o), 32'h200);

        // R12 idle gaps between rows; R11 new frame clears old flags
        send_frame(CASES[0], 2);
        chk("R12 gapped clean frame", 32'(err_flags_o), 32'h0);
        chk("R11 cleared any", 32'(err_any_o), 32'h0);

        // R12 gapped frame still pairs the right rows (carry fault)
        send_frame(CASES[6], 3);
        chk("R12 gapped carry fault", 32'(err_flags_o), 32'h010);

        // R11 latency: clean first, then a wr-without-op opening row
        send_frame(CASES[0], 0);
        drive('{32'd1, 2'd0, 2'd1, 32'd0, 2'd0, 8'h00}, 1'b1, 1'b0);
        chk("R11 one edge after capture", 32'(err_flags_o), 32'h0);
        @(negedge clk);
        chk("R2 two edges after capture", 32'(err_flags_o), 32'h002);

        send_frame(CASES[0], 0);
        chk("R11 final clean", 32'(err_flags_o), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule